// File: doc/BRIEF.md
# Management Frame Master

This block carries out one register access to an external PHY over the two-wire serial management interface. The host places a PHY address, a register number, a read/write select and write data on its inputs and pulses `start`. The block then clocks a complete frame on `mdc`. For each bit time it drives `mdo` and the output-enable `mdo_en` itself. Read data is gathered from `mdi` and handed back with a one-cycle `done` pulse. `busy` stays high for the whole frame.

Every frame opens with a preamble of 32 driven ones. A start pair and a two-bit opcode follow, then the 5-bit PHY address and the 5-bit register number, both sent most significant bit first. A write releases the line for two bit times, drives 16 data bits and releases the line for one final clock, which gives 65 clocks. A read releases the line for one turnaround bit, captures 16 data bits and ends with one released clock, which gives 64 clocks. The `HALF_CYC` parameter sets each half of a bit period as a number of system clocks.

Top module: `mgmt_frame_master`

## Requirements
- R1: In reset and whenever no frame is in progress, `mdc`, `mdo`, `mdo_en`, `busy` and `done` are all 0.
- R2: Bit times 0 to 31 of every frame are driven (`mdo_en`=1) with `mdo`=1.
- R3: Bit times 32 and 33 are driven as 0 then 1. Bit times 34 and 35 carry the opcode, driven: 1,0 when `rd_nwr`=1 (read) and 0,1 when `rd_nwr`=0 (write).
- R4: Bit times 36 to 40 drive `phy_addr` and bit times 41 to 45 drive `reg_addr`, each most significant bit first.
- R5: A write undrives bit times 46 and 47, drives `wr_data` MSB first on bit times 48 to 63 and undrives bit time 64. The frame has 65 `mdc` rising edges.
- R6: A read undrives bit time 46. It captures `mdi` on bit times 47 to 62 as data MSB first and undrives bit time 63. The frame has 64 `mdc` rising edges, and the captured word appears on `rd_data` in the cycle `done` is high.
- R7: `mdc` stays low for `HALF_CYC` system clocks and then high for `HALF_CYC` system clocks in every bit time. `mdo` and `mdo_en` change only while `mdc` is low. `mdi` is sampled on the first system clock edge after `mdc` rises.
- R8: Whenever `mdo_en` is 0, `mdo` is 0.
- R9: `busy` is 1 from the cycle after an accepted `start` until the frame ends. `done` is high for exactly one cycle, the same cycle in which `busy` falls.
- R10: A `start` that arrives while `busy` is 1 is ignored. The frame in progress keeps its original fields, and no further frame follows it.
- R11: `rd_data` changes only when a read completes. A write leaves it holding the last read word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a frame |
| rd_nwr | input | 1 | 1 selects a read, 0 a write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register number |
| wr_data | input | 16 | Data for a write |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame end |
| rd_data | output | 16 | Word captured by the last read |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Management data out |
| mdo_en | output | 1 | Output enable for management data |
| mdi | input | 1 | Management data in |

## Verification
Reads and writes are interleaved with address and data patterns chosen to separate the fields. All-ones and all-zeros fields show up bit-order or field-boundary slips. Alternating and single-bit words expose reversed MSB ordering. A read returning 0x0000 while the line idles high reveals a capture window misplaced by one bit. The bench model of the PHY flips `mdi` during the second system clock of each high phase, so only a sample taken right after the rising edge returns the right word. A second start is injected in the middle of a write, and the bench then confirms that the frame is unchanged, that no extra frame follows and that the previous read word survives.

// File: rtl/mgmt_frame_pkg.sv
package mgmt_frame_pkg;
  localparam int PRE_LEN = 32;
  localparam int FLD_W   = 5;
  localparam int DAT_W   = 16;

  localparam int ST_POS     = PRE_LEN;
  localparam int OP_POS     = ST_POS + 2;
  localparam int PA_POS     = OP_POS + 2;
  localparam int RA_POS     = PA_POS + FLD_W;
  localparam int TA_POS     = RA_POS + FLD_W;
  localparam int RD_DAT_POS = TA_POS + 1;
  localparam int WR_DAT_POS = TA_POS + 2;
  localparam int RD_LAST    = RD_DAT_POS + DAT_W;
  localparam int WR_LAST    = WR_DAT_POS + DAT_W;
  localparam int IDX_W      = $clog2(WR_LAST + 2);
endpackage

// File: rtl/mgmt_bit_timer.sv
module mgmt_bit_timer #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic rise,
  output logic fall,
  output logic samp
);
  logic phase_q;
  logic half_end;
  logic first;

  generate
    if (HALF_CYC > 1) begin : g_cnt
      localparam int CW = $clog2(HALF_CYC);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst || !run || half_end) cnt_q <= '0;
        else                         cnt_q <= cnt_q + 1'b1;
      end
      assign half_end = (cnt_q == CW'(HALF_CYC - 1));
      assign first    = (cnt_q == '0);
    end else begin : g_direct
      assign half_end = 1'b1;
      assign first    = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !run)   phase_q <= 1'b0;
    else if (half_end) phase_q <= ~phase_q;
  end

  assign rise = run && !phase_q && half_end;
  assign fall = run &&  phase_q && half_end;
  assign samp = run &&  phase_q && first;
endmodule

// File: rtl/mgmt_frame_encode.sv
module mgmt_frame_encode
  import mgmt_frame_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  input  logic             is_rd,
  input  logic [FLD_W-1:0] phy,
  input  logic [FLD_W-1:0] rg,
  input  logic [DAT_W-1:0] wd,
  output logic             drv_val,
  output logic             drv_en
);
  int ix;

  always_comb begin
    ix      = int'(idx);
    drv_val = 1'b0;
    drv_en  = 1'b0;
    if (ix < ST_POS) begin
      drv_en  = 1'b1;
      drv_val = 1'b1;
    end else if (ix < OP_POS) begin
      drv_en  = 1'b1;
      drv_val = (ix == ST_POS + 1);
    end else if (ix < PA_POS) begin
      drv_en  = 1'b1;
      drv_val = is_rd ? (ix == OP_POS) : (ix == OP_POS + 1);
    end else if (ix < RA_POS) begin
      drv_en  = 1'b1;
      drv_val = phy[FLD_W - 1 - (ix - PA_POS)];
    end else if (ix < TA_POS) begin
      drv_en  = 1'b1;
      drv_val = rg[FLD_W - 1 - (ix - RA_POS)];
    end else if (!is_rd && ix >= WR_DAT_POS && ix < WR_LAST) begin
      drv_en  = 1'b1;
      drv_val = wd[DAT_W - 1 - (ix - WR_DAT_POS)];
    end
  end
endmodule

// File: rtl/mgmt_frame_master.sv
module mgmt_frame_master
  import mgmt_frame_pkg::*;
#(
  parameter int HALF_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             rd_nwr,
  input  logic [FLD_W-1:0] phy_addr,
  input  logic [FLD_W-1:0] reg_addr,
  input  logic [DAT_W-1:0] wr_data,
  output logic             busy,
  output logic             done,
  output logic [DAT_W-1:0] rd_data,
  output logic             mdc,
  output logic             mdo,
  output logic             mdo_en,
  input  logic             mdi
);
  localparam logic [IDX_W-1:0] RD_LAST_I = IDX_W'(RD_LAST);
  localparam logic [IDX_W-1:0] WR_LAST_I = IDX_W'(WR_LAST);
  localparam logic [IDX_W-1:0] RD_DAT_I  = IDX_W'(RD_DAT_POS);

  logic             busy_q, done_q, mdc_q, mdo_q, en_q;
  logic             lat_rd;
  logic [FLD_W-1:0] lat_phy, lat_reg;
  logic [DAT_W-1:0] lat_wd, cap_sh, rd_q;
  logic [IDX_W-1:0] idx_q, n_idx;
  logic             n_rd, n_val, n_en;
  logic [FLD_W-1:0] n_phy, n_reg;
  logic [DAT_W-1:0] n_wd;
  logic             t_rise, t_fall, t_samp;
  logic             c_last, c_cap;

  mgmt_bit_timer #(.HALF_CYC(HALF_CYC)) timer_i (
    .clk(clk), .rst(rst), .run(busy_q),
    .rise(t_rise), .fall(t_fall), .samp(t_samp)
  );

  // Next bit comes from the incoming fields when idle, from latched ones when busy.
  assign n_idx = busy_q ? idx_q + 1'b1 : '0;
  assign n_rd  = busy_q ? lat_rd  : rd_nwr;
  assign n_phy = busy_q ? lat_phy : phy_addr;
  assign n_reg = busy_q ? lat_reg : reg_addr;
  assign n_wd  = busy_q ? lat_wd  : wr_data;

  mgmt_frame_encode enc_i (
    .idx(n_idx), .is_rd(n_rd), .phy(n_phy), .rg(n_reg), .wd(n_wd),
    .drv_val(n_val), .drv_en(n_en)
  );

  assign c_last = lat_rd ? (idx_q == RD_LAST_I) : (idx_q == WR_LAST_I);
  assign c_cap  = lat_rd && (idx_q >= RD_DAT_I) && (idx_q < RD_LAST_I);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      mdc_q   <= 1'b0;
      mdo_q   <= 1'b0;
      en_q    <= 1'b0;
      lat_rd  <= 1'b0;
      lat_phy <= '0;
      lat_reg <= '0;
      lat_wd  <= '0;
      idx_q   <= '0;
      cap_sh  <= '0;
      rd_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q  <= 1'b1;
          lat_rd  <= rd_nwr;
          lat_phy <= phy_addr;
          lat_reg <= reg_addr;
          lat_wd  <= wr_data;
          idx_q   <= '0;
          mdo_q   <= n_val;
          en_q    <= n_en;
        end
      end else begin
        if (t_rise) mdc_q <= 1'b1;
        if (t_samp && c_cap) cap_sh <= {cap_sh[DAT_W-2:0], mdi};
        if (t_fall) begin
          mdc_q <= 1'b0;
          if (c_last) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            mdo_q  <= 1'b0;
            en_q   <= 1'b0;
            if (lat_rd) rd_q <= cap_sh;
          end else begin
            idx_q <= n_idx;
            mdo_q <= n_val;
            en_q  <= n_en;
          end
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rd_data = rd_q;
  assign mdc     = mdc_q;
  assign mdo     = mdo_q;
  assign mdo_en  = en_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (!mdc_q && !mdo_q && !en_q));                       // R1
  AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (mdc_q && $past(mdc_q)) |-> ($stable(mdo_q) && $stable(en_q)));  // R7
  AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> !mdo_q);                                               // R8
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!busy_q && $past(busy_q)));                          // R9
  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> ($stable(lat_phy) && $stable(lat_reg) && $stable(lat_wd) && $stable(lat_rd))); // R10
  AST_RDATA_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    !done_q |-> $stable(rd_q));                                      // R11
endmodule

// File: tb/mgmt_frame_master_tb_top.sv
module mgmt_frame_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;
  localparam int WD_LIMIT   = 150000;
  localparam int NVEC       = 5;
  // {rd_nwr, phy_addr, reg_addr, wr_data, phy_response}
  localparam logic [42:0] VECS [NVEC] = '{
    {1'b1, 5'h01, 5'h02, 16'h0000, 16'hA5C3},
    {1'b0, 5'h1F, 5'h00, 16'h8001, 16'h0000},
    {1'b1, 5'h00, 5'h1F, 16'h0000, 16'h0000},
    {1'b0, 5'h0A, 5'h15, 16'h5A3C, 16'h0000},
    {1'b1, 5'h15, 5'h0A, 16'h0000, 16'h0001}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        rd_nwr = 1'b0;
  logic [4:0]  phy_addr = '0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic        mdi = 1'b1;
  logic        busy, done, mdc, mdo, mdo_en;
  logic [15:0] rd_data;

  int total = 0;
  int fails = 0;
  logic [15:0] last_rd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mgmt_frame_master #(.HALF_CYC(HALF)) dut_i (
    .clk(clk), .rst(rst), .start(start), .rd_nwr(rd_nwr),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .rd_data(rd_data),
    .mdc(mdc), .mdo(mdo), .mdo_en(mdo_en), .mdi(mdi)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_bit(int i, logic rd, logic [4:0] pa,
                                         logic [4:0] ra, logic [15:0] wd);
    if (i < 32)  return 2'b11;
    if (i == 32) return 2'b10;
    if (i == 33) return 2'b11;
    if (i == 34) return {1'b1, rd};
    if (i == 35) return {1'b1, !rd};
    if (i < 41)  return {1'b1, pa[40 - i]};
    if (i < 46)  return {1'b1, ra[45 - i]};
    if (rd)      return 2'b00;
    if (i >= 48 && i < 64) return {1'b1, wd[63 - i]};
    return 2'b00;
  endfunction

  task automatic run_txn(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd, input logic [15:0] rsp, input bit inj);
    logic [79:0] rec_o, rec_e;
    int rises = 0, lo_cnt = 1, hi_cnt = 0, tmr_err = 0, cyc = 0, busy_drop = 0;
    int pre_err = 0, hdr_err = 0, adr_err = 0, tail_err = 0, nexp;
    logic prev = 1'b0;
    bit seen_done = 0;
    rec_o = '0;
    rec_e = '0;
    @(negedge clk);
    rd_nwr = rd; phy_addr = pa; reg_addr = ra; wr_data = wd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && mdo_en && mdo && !mdc, "R9", "busy/first bit after start",
        {busy, mdo_en, mdo, mdc}, 4'b1110);
    mdi = 1'b1;
    while (!seen_done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (inj && cyc == 40) begin
        start = 1'b1; rd_nwr = ~rd; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~wd;
      end
      if (inj && cyc == 41) start = 1'b0;
      if (done) begin
        seen_done = 1;
      end else begin
        if (!busy) busy_drop++;
        if (mdc && !prev) begin
          if (lo_cnt != HALF) tmr_err++;
          if (rises < 80) begin rec_o[rises] = mdo; rec_e[rises] = mdo_en; end
          rises++;
          hi_cnt = 1;
        end else if (mdc) begin
          hi_cnt++;
          if (hi_cnt == 2) mdi = ~mdi;  // late sampling would see this
        end else if (prev) begin
          if (hi_cnt != HALF) tmr_err++;
          lo_cnt = 1;
        end else begin
          lo_cnt++;
        end
        if (!mdc) mdi = (rd && rises >= 47 && rises <= 62) ? rsp[62 - rises] : 1'b1;
        prev = mdc;
      end
    end
    nexp = rd ? 64 : 65;
    for (int i = 0; i < 80; i++) begin
      if (i < rises) begin
        logic [1:0] e;
        e = exp_bit(i, rd, pa, ra, wd);
        if ({rec_e[i], rec_o[i]} != e) begin
          if (i < 32) pre_err++;
          else if (i < 36) hdr_err++;
          else if (i < 46) adr_err++;
          else tail_err++;
        end
      end
    end
    chk(seen_done, "R9", "done pulse seen", seen_done, 1);
    chk(busy_drop == 0, "R9", "busy low inside frame", busy_drop, 0);
    chk(rises == nexp, rd ? "R6" : "R5", "mdc rising edges", rises, nexp);
    chk(pre_err == 0, "R2", "preamble mismatches", pre_err, 0);
    chk(hdr_err == 0, "R3", "start/opcode mismatches", hdr_err, 0);
    chk(adr_err == 0, "R4", "address mismatches", adr_err, 0);
    chk(tail_err == 0, rd ? "R6" : "R5", "turnaround/data mismatches (undriven bits low, R8)", tail_err, 0);
    chk(tmr_err == 0, "R7", "half-period length errors", tmr_err, 0);
    if (rd) last_rd = rsp;
    chk(rd_data == last_rd, rd ? "R6" : "R11", "rd_data at done", rd_data, last_rd);
    chk(!busy && !mdc && !mdo && !mdo_en, "R1", "idle lines at done",
        {busy, mdc, mdo, mdo_en}, 0);
    @(negedge clk);
    chk(!done, "R9", "done lasts one cycle", done, 0);
    if (inj) begin
      repeat (5) @(negedge clk);
      chk(!busy && !mdc, "R10", "no frame after ignored start", {busy, mdc}, 0);
      chk(rd_data == last_rd, "R11", "rd_data kept after write", rd_data, last_rd);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    total++;
    fails++;
    $display("FAIL R9 watchdog: cycles %0d expected below %0d", WD_LIMIT, WD_LIMIT);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!busy && !done && !mdc && !mdo && !mdo_en, "R1", "outputs in reset",
        {busy, done, mdc, mdo, mdo_en}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !mdc && !mdo && !mdo_en && rd_data == 16'h0, "R1",
        "outputs after reset", {busy, done, mdc, mdo, mdo_en, rd_data}, 0);
    for (int k = 0; k < NVEC; k++) begin
      logic [42:0] v;
      v = VECS[k];
      run_txn(v[42], v[41:37], v[36:32], v[31:16], v[15:0], 1'b0);
    end
    // Second start during a write: R10, and the earlier read word must stay (R11).
    run_txn(1'b0, 5'h13, 5'h0C, 16'h1234, 16'h0000, 1'b1);
    // Read after the injected write picks up fresh data.
    run_txn(1'b1, 5'h1F, 5'h1F, 16'h0000, 16'h7E81, 1'b0);
    finish_run();
  end
endmodule